// File: doc/BRIEF.md
# Preset-Count Termination Scaler

This block holds a bank of down-counters, sixteen by default. Before a run each counter is loaded with a preset number of events. During the run every event seen by a channel takes one off its counter. An event comes either from that channel's external input or from a shared internal pulse source. The internal source runs at the clock rate, or at one half, one quarter or one eighth of it.

A stop mask names the channels that are allowed to end the run. The run ends on the first clock edge on which any masked channel arrives at zero. On that edge every channel stops counting at once, a finished flag is set, and a vector records each masked channel that arrived at zero on that edge. If interrupts are enabled, an interrupt line follows the finished flag.

Software must clear the finished flag before it can start a new run. Any counter can be read back at any time through a channel-select read port.

Top module: `preset_scaler`

## Requirements
- R1: After reset, `running`, `done`, `irq` and `hit_chs` are 0 and every counter reads 0.
- R2: A `cfg_we` pulse while not running loads `cfg_data` into counter `cfg_ch`, and the new value is readable on `rd_val` after the next edge. A `cfg_we` pulse while running leaves all counters unchanged.
- R3: A `start` pulse is accepted only while neither `running` nor `done` is set, and `running` rises on the edge that samples it. A `start` pulse while `done` is set is ignored.
- R4: A channel whose `src_sel` bit is 1 takes the internal source. With `rate_code` c (0 to 3), that source gives one event every 2^c clocks. The first event falls in running cycle 2^c. A masked channel with preset P therefore ends the run P·2^c edges after the start edge.
- R5: A channel whose `src_sel` bit is 0 counts one event for each 0-to-1 transition of its `ext_evt` bit while running. The event is counted on the first edge that samples the input high. An input held high does not count again.
- R6: Each event lowers its counter by one. A counter at zero stays at zero. An unmasked channel that arrives at zero does not end the run.
- R7: On the edge where a masked channel (`term_mask` bit i = 1) arrives at zero, `running` falls and `done` rises. Events in that same cycle still count, and no counter changes after that edge.
- R8: On termination, bit i of `hit_chs` is set for each masked channel i that was at zero on that edge. Several simultaneous arrivals are all recorded, and no unmasked bit is set.
- R9: `irq` is 1 exactly when `done` is 1 and `irq_en` is 1.
- R10: A `clr_done` pulse clears `done` and `hit_chs` on the next edge. A `start` in the same cycle as that `clr_done` is ignored.
- R11: A masked channel that holds zero when the run starts ends the run on the first edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Preset write strobe |
| cfg_ch | input | CH_W | Channel written by `cfg_we` |
| cfg_data | input | CW | Preset value |
| term_mask | input | NCH | Channels allowed to end the run |
| src_sel | input | NCH | Per-channel source: 1 internal, 0 external |
| rate_code | input | 2 | Internal source divide: 0 /1, 1 /2, 2 /4, 3 /8 |
| irq_en | input | 1 | Interrupt enable |
| start | input | 1 | Start request |
| clr_done | input | 1 | Clears the finished flag and hit vector |
| ext_evt | input | NCH | External event inputs, synchronous to `clk` |
| rd_ch | input | CH_W | Counter selected for read-back |
| rd_val | output | CW | Current value of counter `rd_ch` |
| running | output | 1 | Run in progress |
| done | output | 1 | Finished flag |
| irq | output | 1 | Interrupt request |
| hit_chs | output | NCH | Masked channels that ended the run |

## Verification
Every result leaves a register one edge after the cycle that caused it, and `rd_val` is a combinational view of those registers:
- An external rising level appears in the counter on the edge that first samples it.
- A preset write shows on `rd_val` after its sampling edge.
- `running` rises on the edge that samples `start`.
- A masked internal-source channel with preset P and code c brings `done` exactly P·2^c edges after the start edge.

The bench drives inputs on falling edges and samples outputs on later falling edges. For each run it checks that `done` is still low one edge before the computed edge and high on that edge.

// File: rtl/scaler_pkg.sv
// Package: shared constants, run-state type and the rate-mask helper
// for the preset-count scaler. Assumes a 2-bit rate code.
package scaler_pkg;

    localparam int RATE_W = 2;
    localparam int DIV_W  = (1 << RATE_W) - 1;

    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_DONE   = 2'd2
    } run_state_t;

    // Low-bit mask whose all-ones match marks one internal event.
    function automatic logic [DIV_W-1:0] rate_mask(input logic [RATE_W-1:0] code);
        return DIV_W'((32'd1 << code) - 32'd1);
    endfunction

endpackage

// File: rtl/sc_edge_det.sv
// sc_edge_det: per-bit rising-edge detector for the external event inputs.
// Assumes the inputs are already synchronous to clk. The history register
// runs at all times so that a level held across a start does not count.
module sc_edge_det #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sig_in,
    output logic [NCH-1:0] rise
);
    logic [NCH-1:0] prev_q;

    // Remember the previous input level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/sc_pulse_gen.sv
// sc_pulse_gen: internal event source. Restarts at phase zero when a run
// is accepted and then emits one tick every 2^code clocks while enabled.
// Assumes the rate code is held steady during a run.
module sc_pulse_gen
    import scaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate_code,
    output logic              tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] msk;

    assign msk = rate_mask(rate_code);

    // Phase counter: cleared on run start, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (enable)  phase_q <= phase_q + DIV_W'(1);
    end

    assign tick = enable && ((phase_q & msk) == msk);
endmodule

// File: rtl/sc_channel.sv
// sc_channel: one preset down-counter. Loads on request, takes one off per
// event, and saturates at zero. Flags when it is at zero or reaches zero
// in this cycle; the caller qualifies that flag with the run state.
module sc_channel #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          ev,
    output logic [CW-1:0] cnt,
    output logic          reach
);
    logic [CW-1:0] cnt_q;

    // Counter register: load has priority, then a saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (ev && cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
    end

    assign cnt   = cnt_q;
    assign reach = (cnt_q == '0) || (ev && cnt_q == CW'(1));
endmodule

// File: rtl/sc_ctrl.sv
// sc_ctrl: run controller. Idle -> active on an accepted start, active ->
// done when any masked channel reaches zero, done -> idle on clear.
// Latches the set of masked channels that ended the run.
module sc_ctrl
    import scaler_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           clr_done,
    input  logic [NCH-1:0] reach_vec,
    input  logic [NCH-1:0] term_mask,
    output logic           start_ok,
    output logic           running,
    output logic           done,
    output logic [NCH-1:0] hit_chs
);
    run_state_t     st_q;
    logic [NCH-1:0] hit_q;
    logic [NCH-1:0] hit_now;

    assign start_ok = (st_q == RUN_IDLE) && start;
    assign hit_now  = (st_q == RUN_ACTIVE) ? (reach_vec & term_mask) : '0;

    // State register and termination record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RUN_IDLE;
            hit_q <= '0;
        end else begin
            case (st_q)
                RUN_IDLE:   if (start) st_q <= RUN_ACTIVE;
                RUN_ACTIVE: if (|hit_now) begin
                                st_q  <= RUN_DONE;
                                hit_q <= hit_now;
                            end
                RUN_DONE:   if (clr_done) begin
                                st_q  <= RUN_IDLE;
                                hit_q <= '0;
                            end
                default:    st_q <= RUN_IDLE;
            endcase
        end
    end

    assign running = (st_q == RUN_ACTIVE);
    assign done    = (st_q == RUN_DONE);
    assign hit_chs = hit_q;
endmodule

// File: rtl/preset_scaler.sv
// preset_scaler: top of the preset-count termination scaler. Instantiates
// the run controller, the internal pulse source, the external edge
// detectors and one down-counter per channel. Assumes all inputs are
// synchronous to clk.
module preset_scaler
    import scaler_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int CW   = 32,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [CW-1:0]     cfg_data,
    input  logic [NCH-1:0]    term_mask,
    input  logic [NCH-1:0]    src_sel,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              irq_en,
    input  logic              start,
    input  logic              clr_done,
    input  logic [NCH-1:0]    ext_evt,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CW-1:0]     rd_val,
    output logic              running,
    output logic              done,
    output logic              irq,
    output logic [NCH-1:0]    hit_chs
);
    logic           start_ok;
    logic           int_tick;
    logic [NCH-1:0] ext_rise;
    logic [NCH-1:0] reach_vec;
    logic [CW-1:0]  cnt_arr [NCH];

    sc_ctrl #(.NCH(NCH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clr_done  (clr_done),
        .reach_vec (reach_vec),
        .term_mask (term_mask),
        .start_ok  (start_ok),
        .running   (running),
        .done      (done),
        .hit_chs   (hit_chs)
    );

    sc_pulse_gen u_pgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start_ok),
        .enable    (running),
        .rate_code (rate_code),
        .tick      (int_tick)
    );

    sc_edge_det #(.NCH(NCH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (ext_evt),
        .rise   (ext_rise)
    );

    // One counter per channel, source picked by its select bit.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ch_ev;
        logic ch_load;
        assign ch_ev   = running && (src_sel[i] ? int_tick : ext_rise[i]);
        assign ch_load = cfg_we && !running && (cfg_ch == CH_W'(i));
        sc_channel #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ch_load),
            .load_val (cfg_data),
            .ev       (ch_ev),
            .cnt      (cnt_arr[i]),
            .reach    (reach_vec[i])
        );
    end

    assign rd_val = cnt_arr[rd_ch];
    assign irq    = done && irq_en;
endmodule

// File: rtl/preset_scaler_chk.sv
// preset_scaler_chk: protocol checks on the scaler's run-control ports.
module preset_scaler_chk #(
    parameter int NCH = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           clr_done,
    input logic [NCH-1:0] term_mask,
    input logic           running,
    input logic           done,
    input logic           irq,
    input logic [NCH-1:0] hit_chs
);
    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(start) && !$past(done)));
    // R7
    stop_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> done);
    // R7
    run_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && done));
    // R8
    hit_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ((hit_chs != '0) && ((hit_chs & ~$past(term_mask)) == '0)));
    // R9
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done);
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clr_done) |=> (!done && hit_chs == '0));
endmodule

bind preset_scaler preset_scaler_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .clr_done  (clr_done),
    .term_mask (term_mask),
    .running   (running),
    .done      (done),
    .irq       (irq),
    .hit_chs   (hit_chs)
);

// File: tb/test_preset_scaler.sv
module test_preset_scaler;
    localparam int NCH = 16;
    localparam int CW  = 32;
    localparam int CHW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_we, irq_en, start, clr_done;
    logic [CHW-1:0] cfg_ch, rd_ch;
    logic [CW-1:0]  cfg_data;
    logic [NCH-1:0] term_mask, src_sel, ext_evt;
    logic [1:0]     rate_code;
    logic [CW-1:0]  rd_val;
    logic           running, done, irq;
    logic [NCH-1:0] hit_chs;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    preset_scaler #(.NCH(NCH), .CW(CW)) i_preset_scaler (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_data(cfg_data), .term_mask(term_mask), .src_sel(src_sel),
        .rate_code(rate_code), .irq_en(irq_en), .start(start),
        .clr_done(clr_done), .ext_evt(ext_evt), .rd_ch(rd_ch),
        .rd_val(rd_val), .running(running), .done(done), .irq(irq),
        .hit_chs(hit_chs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rd(input int ch, output logic [CW-1:0] v);
        rd_ch = CHW'(ch);
        #1 v = rd_val;
    endtask

    task automatic load(input int ch, input int val);
        @(negedge clk);
        cfg_we = 1; cfg_ch = CHW'(ch); cfg_data = CW'(val);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Leaves the bench at the falling edge right after the start edge.
    task automatic go();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic clear();
        @(negedge clk); clr_done = 1;
        @(negedge clk); clr_done = 0;
    endtask

    task automatic t_reset();
        logic [CW-1:0] v;
        chk("R1 running", running, 0);
        chk("R1 done", done, 0);
        chk("R1 irq", irq, 0);
        chk("R1 hit_chs", hit_chs, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, v);
            chk("R1 counter", v, 0);
        end
    endtask

    task automatic t_load();
        logic [CW-1:0] v;
        load(3, 32'hDEAD_BEEF);
        rd(3, v); chk("R2 preset readback", v, 32'hDEAD_BEEF);
        load(3, 0);
        rd(3, v); chk("R2 preset reload", v, 0);
    endtask

    task automatic t_rate(input int code);
        logic [CW-1:0] v;
        int n;
        n = 3 << code;
        load(0, 3); load(1, 100);
        term_mask = 16'h0001; src_sel = '1; rate_code = 2'(code);
        go();
        edges(n - 1);
        chk("R4 still running before due edge", running, 1);
        chk("R4 not done before due edge", done, 0);
        edges(1);
        chk("R4 done on due edge", done, 1);
        chk("R7 running falls", running, 0);
        chk("R8 hit ch0", hit_chs, 16'h0001);
        rd(1, v); chk("R4 sibling count", v, 97);
        edges(10);
        rd(1, v); chk("R7 frozen after stop", v, 97);
        clear();
    endtask

    task automatic t_ext();
        logic [CW-1:0] v;
        load(1, 2); load(2, 5);
        term_mask = 16'h0002; src_sel = '0; rate_code = 0;
        go();
        ext_evt = 16'h0006;
        edges(1);
        rd(1, v); chk("R5 first rise ch1", v, 1);
        rd(2, v); chk("R5 first rise ch2", v, 4);
        edges(2);
        rd(1, v); chk("R5 held level ignored", v, 1);
        chk("R6 still running", running, 1);
        ext_evt = 0; edges(1);
        ext_evt = 16'h0006; edges(1);
        rd(1, v); chk("R6 ch1 reaches zero", v, 0);
        rd(2, v); chk("R7 same-cycle event counts", v, 3);
        chk("R7 done on reach", done, 1);
        ext_evt = 0; edges(1); ext_evt = 16'h0004; edges(1);
        rd(2, v); chk("R7 no count after stop", v, 3);
        ext_evt = 0;
        clear();
    endtask

    task automatic t_unmasked();
        logic [CW-1:0] v;
        load(0, 5); load(3, 2);
        term_mask = 16'h0001; src_sel = '1; rate_code = 0;
        go();
        edges(3);
        rd(3, v); chk("R6 unmasked at zero", v, 0);
        chk("R6 unmasked zero keeps run", running, 1);
        edges(2);
        chk("R6 masked ends run", done, 1);
        rd(3, v); chk("R6 saturates at zero", v, 0);
        clear();
    endtask

    task automatic t_multi_irq();
        logic [CW-1:0] v;
        load(4, 3); load(5, 3); load(6, 4); load(7, 9);
        term_mask = 16'h0070; src_sel = 16'hFF7F; rate_code = 0; irq_en = 1;
        go();
        @(negedge clk); cfg_we = 1; cfg_ch = 7; cfg_data = 77;
        @(negedge clk); cfg_we = 0;
        edges(1);
        chk("R8 done together", done, 1);
        chk("R8 two hits recorded", hit_chs, 16'h0030);
        chk("R9 irq with enable", irq, 1);
        rd(7, v); chk("R2 write while running ignored", v, 9);
        irq_en = 0; #1;
        chk("R9 irq masked", irq, 0);
        go();
        edges(1);
        chk("R3 start ignored while done", running, 0);
        chk("R3 done kept", done, 1);
        @(negedge clk); clr_done = 1; start = 1;
        @(negedge clk); clr_done = 0; start = 0;
        chk("R10 done cleared", done, 0);
        chk("R10 hits cleared", hit_chs, 0);
        chk("R10 start with clear ignored", running, 0);
    endtask

    task automatic t_zero_preset();
        logic [CW-1:0] v;
        load(8, 0); load(9, 50);
        term_mask = 16'h0100; src_sel = '1; rate_code = 0;
        go();
        chk("R3 running after start", running, 1);
        edges(1);
        chk("R11 zero preset ends run", done, 1);
        chk("R11 hit ch8", hit_chs, 16'h0100);
        rd(9, v); chk("R11 one event counted", v, 49);
        clear();
    endtask

    initial begin
        rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_data = 0; term_mask = 0;
        src_sel = 0; rate_code = 0; irq_en = 0; start = 0; clr_done = 0;
        ext_evt = 0; rd_ch = 0;
        edges(3);
        rst_n = 1;
        edges(1);
        t_reset();
        t_load();
        for (int c = 0; c < 4; c++) t_rate(c);
        t_ext();
        t_unmasked();
        t_multi_irq();
        t_zero_preset();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule